// File: doc/BRIEF.md
# Four-Mode Configurable GPIO Port

This block controls a port of up to eight pins. Each pin selects its own drive behaviour through two mode registers: quasi-bidirectional, push-pull, input-only or open-drain. The block turns the mode bits and the output data register into three enables per pin: a pull-down enable, a strong pull-up enable and a weak pull-up enable. The pad cell uses these enables to drive the pin. The level of each pin comes back through a two-flop synchronizer, so the rest of the chip can read it safely.

Software reaches the output data register, the two mode registers and the synchronized pin levels through a simple register bus. The bus has a one-cycle write strobe and a combinational read. When a quasi-bidirectional pin's output bit goes from low to high, the block briefly drives the strong pull-up so that the pin rises quickly. After that, the weak pull-up alone holds the pin high.

Top module: `gpio4m_port`

## Requirements
- R1: The mode of pin i is the pair {M0[i], M1[i]}: 00 is quasi-bidirectional, 01 is push-pull, 10 is input-only and 11 is open-drain. The bus addresses are 0 for the output data register, 1 for M0, 2 for M1 and 3 for the synchronized pin levels.
- R2: Reset loads M0 with all ones, M1 with all zeros and the data register with all ones. All pins are then input-only and every pd_en, spu_en and wpu_en bit is 0.
- R3: An input-only pin has pd_en, spu_en and wpu_en at 0 for any data register value.
- R4: An open-drain pin has pd_en equal to the inverse of its data bit. Its spu_en and wpu_en are always 0, including right after a 0-to-1 data change.
- R5: A quasi-bidirectional pin has pd_en equal to the inverse of its data bit and wpu_en equal to its data bit.
- R6: When the data bit of a quasi-bidirectional pin goes from 0 to 1, spu_en is 1 for exactly 2 cycles. The pulse starts in the first cycle in which the data register holds 1. In steady state spu_en is 0.
- R7: A push-pull pin has pd_en equal to the inverse of its data bit and spu_en equal to its data bit. wpu_en is 0.
- R8: pin_val equals pad_in delayed by two clock edges.
- R9: A read returns the register selected by bus_addr. A write to address 3 changes no register.
- R10: On no pin is pd_en 1 in the same cycle as spu_en or wpu_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| pad_in | input | W | Raw pin levels from the pads |
| pd_en | output | W | Pull-down enable per pin |
| spu_en | output | W | Strong pull-up enable per pin |
| wpu_en | output | W | Weak pull-up enable per pin |
| pin_val | output | W | Synchronized pin levels |

## Verification
The assertions assume that rst_n is held low until the first clock edges have passed. They also assume that pad_in is sampled only at rising edges, so the two-edge delay of pin_val is well defined once two cycles have passed after reset. The pulse check applies only to pins that were quasi-bidirectional in both the current and the previous cycle. The stimulus therefore leaves pin modes unchanged while a strong pull-up pulse is being measured. The bench drives the bus and pad_in only at falling edges and holds each write for exactly one rising edge.

// File: rtl/gpio4m_pkg.sv
package gpio4m_pkg;
   // Pin drive mode, encoded as {M0 bit, M1 bit}
   typedef enum logic [1:0] {
      MODE_QBIDIR = 2'b00,
      MODE_PUSHPL = 2'b01,
      MODE_INONLY = 2'b10,
      MODE_OPENDR = 2'b11
   } pin_mode_e;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_M0   = 2'd1;
   localparam logic [1:0] ADDR_M1   = 2'd2;
   localparam logic [1:0] ADDR_PINS = 2'd3;
endpackage

// File: rtl/gpio4m_regs.sv
module gpio4m_regs
   import gpio4m_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_wr,
   input  logic [1:0]   bus_addr,
   input  logic [W-1:0] bus_wdata,
   input  logic [W-1:0] pin_val,
   output logic [W-1:0] bus_rdata,
   output logic [W-1:0] data_q,
   output logic [W-1:0] m0_q,
   output logic [W-1:0] m1_q
);
   localparam logic [W-1:0] ONES  = {W{1'b1}};
   localparam logic [W-1:0] ZEROS = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= ONES;
         m0_q   <= ONES;
         m1_q   <= ZEROS;
      end else if (bus_wr) begin
         case (bus_addr)
            ADDR_DATA: data_q <= bus_wdata;
            ADDR_M0:   m0_q   <= bus_wdata;
            ADDR_M1:   m1_q   <= bus_wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_DATA: bus_rdata = data_q;
         ADDR_M0:   bus_rdata = m0_q;
         ADDR_M1:   bus_rdata = m1_q;
         default:   bus_rdata = pin_val;
      endcase
   end
endmodule

// File: rtl/gpio4m_sync.sv
module gpio4m_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio4m_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio4m_pin_drv.sv
module gpio4m_pin_drv
   import gpio4m_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 2,
   parameter bit          DOUT_RST  = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      dout,
   output logic      pd,
   output logic      spu,
   output logic      wpu
);
   localparam int unsigned CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

   logic boost;

   if (PULSE_CYC == 0) begin : g_no_boost
      assign boost = 1'b0;
   end else begin : g_boost
      logic          dout_d;
      logic [CW-1:0] cnt_q;
      logic          rise;

      assign rise = dout & ~dout_d;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout_d <= DOUT_RST;
            cnt_q  <= '0;
         end else begin
            dout_d <= dout;
            if (rise)              cnt_q <= LOAD;
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
      end

      // The pulse covers the rising cycle plus PULSE_CYC-1 more cycles
      assign boost = dout & (rise | (cnt_q != '0));
   end

   always_comb begin
      pd  = 1'b0;
      spu = 1'b0;
      wpu = 1'b0;
      case (mode)
         MODE_QBIDIR: begin
            pd  = ~dout;
            wpu = dout;
            spu = boost;
         end
         MODE_PUSHPL: begin
            pd  = ~dout;
            spu = dout;
         end
         MODE_OPENDR: pd = ~dout;
         default: ;
      endcase
   end
endmodule

// File: rtl/gpio4m_port.sv
module gpio4m_port
   import gpio4m_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned PULSE_CYC = 2,
   parameter int unsigned SYNC_STG  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_wr,
   input  logic [1:0]   bus_addr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] pd_en,
   output logic [W-1:0] spu_en,
   output logic [W-1:0] wpu_en,
   output logic [W-1:0] pin_val
);
   if (W < 1 || W > 8) begin : g_bad_width
      $error("gpio4m_port: W must be 1 to 8");
   end
   if (PULSE_CYC > 16) begin : g_bad_pulse
      $error("gpio4m_port: PULSE_CYC above 16 is not supported");
   end

   logic [W-1:0] data_q, m0_q, m1_q;

   gpio4m_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .pin_val  (pin_val),
      .bus_rdata(bus_rdata),
      .data_q   (data_q),
      .m0_q     (m0_q),
      .m1_q     (m1_q)
   );

   gpio4m_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_val)
   );

   for (genvar i = 0; i < W; i++) begin : g_pin
      gpio4m_pin_drv #(.PULSE_CYC(PULSE_CYC), .DOUT_RST(1'b1)) u_drv (
         .clk  (clk),
         .rst_n(rst_n),
         .mode (pin_mode_e'({m0_q[i], m1_q[i]})),
         .dout (data_q[i]),
         .pd   (pd_en[i]),
         .spu  (spu_en[i]),
         .wpu  (wpu_en[i])
      );
   end
endmodule

// File: rtl/gpio4m_port_chk.sv
module gpio4m_port_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] m0,
   input logic [W-1:0] m1,
   input logic [W-1:0] dout,
   input logic [W-1:0] pd_en,
   input logic [W-1:0] spu_en,
   input logic [W-1:0] wpu_en,
   input logic [W-1:0] pad_in,
   input logic [W-1:0] pin_val
);
   logic [W-1:0] qb, inonly, odrain;
   logic [1:0]   age_q;

   assign qb     = ~m0 & ~m1;
   assign inonly =  m0 & ~m1;
   assign odrain =  m0 &  m1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
   end

   a_r3_inonly_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((pd_en | spu_en | wpu_en) & inonly) == '0);

   a_r4_od_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
      ((spu_en | wpu_en) & odrain) == '0);

   a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_en & (spu_en | wpu_en)) == '0);

   // R6: a fresh strong pulse on a steady quasi-bidirectional pin needs a 0-to-1 data change
   a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0) |->
      ((qb & $past(qb) & spu_en & ~$past(spu_en) & ~(dout & ~$past(dout))) == '0));

   a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (pin_val == $past(pad_in, 2)));
endmodule

bind gpio4m_port gpio4m_port_chk #(.W(W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .m0     (m0_q),
   .m1     (m1_q),
   .dout   (data_q),
   .pd_en  (pd_en),
   .spu_en (spu_en),
   .wpu_en (wpu_en),
   .pad_in (pad_in),
   .pin_val(pin_val)
);

// File: tb/tb_gpio4m_port.sv
module tb_gpio4m_port;
   localparam int W = 8;

   typedef struct {
      string      tag;
      int         kind;   // 0 pd, 1 spu, 2 wpu, 3 pin_val, 4 rdata
      logic [7:0] exp;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pd_en, spu_en, wpu_en, pin_val;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   item_t q[$];

   always #5 clk = ~clk;

   gpio4m_port #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en), .pin_val(pin_val)
   );

   // Monitor: compares queued expectations shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = pd_en;
               1: act = spu_en;
               2: act = wpu_en;
               3: act = pin_val;
               default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind%0d: actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic push(input string tag, input int kind, input logic [7:0] exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic exp_drv(input string tag, input logic [7:0] pd, input logic [7:0] spu,
                          input logic [7:0] wpu);
      push(tag, 0, pd); push(tag, 1, spu); push(tag, 2, wpu);
   endtask

   // Steady-state drive model from the mode table
   task automatic exp_model(input string tag, input logic [7:0] d, input logic [7:0] m0,
                            input logic [7:0] m1);
      logic [7:0] qb, pp, io;
      qb = ~m0 & ~m1; pp = ~m0 & m1; io = m0 & ~m1;
      exp_drv(tag, ~d & ~io, d & pp, d & qb);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] v);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] v);
      bus_addr = a;
      push(tag, 4, v);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      exp_drv("R2 reset drives", 8'h00, 8'h00, 8'h00);
      rd("R2 reset data", 2'd0, 8'hFF);
      rd("R2 reset M0", 2'd1, 8'hFF);
      rd("R2 reset M1", 2'd2, 8'h00);

      // R3: input-only ignores data changes
      wr(2'd0, 8'h00);
      exp_drv("R3 inonly data0", 8'h00, 8'h00, 8'h00);
      @(negedge clk);
      wr(2'd0, 8'hFF);
      exp_drv("R3 inonly rise", 8'h00, 8'h00, 8'h00);
      @(negedge clk);

      // R5: all quasi-bidirectional, data high, no rise
      wr(2'd1, 8'h00);
      exp_drv("R5 qb high", 8'h00, 8'h00, 8'hFF);
      @(negedge clk);
      wr(2'd0, 8'h00);
      exp_drv("R5 qb low", 8'hFF, 8'h00, 8'h00);
      @(negedge clk);

      // R6: strong pulse for exactly 2 cycles
      wr(2'd0, 8'hA5);
      exp_drv("R6 pulse cyc1", 8'h5A, 8'hA5, 8'hA5);
      @(negedge clk);
      push("R6 pulse cyc2", 1, 8'hA5);
      @(negedge clk);
      push("R6 pulse end", 1, 8'h00);
      @(negedge clk);
      push("R6 pulse stays off", 1, 8'h00);
      @(negedge clk);

      // R1/R7: mixed modes, steady state
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'h33);
      wr(2'd0, 8'h5A);
      repeat (3) @(negedge clk);
      exp_model("R1 R7 mixed 5A", 8'h5A, 8'h0F, 8'h33);
      @(negedge clk);
      // QB pins 0xC0, push-pull 0x30, rising bits 0xA5
      wr(2'd0, 8'hFF);
      push("R6 R7 mixed rise", 1, 8'hB0);
      @(negedge clk);
      push("R6 mixed cyc2", 1, 8'hB0);
      @(negedge clk);
      exp_model("R1 R7 mixed FF", 8'hFF, 8'h0F, 8'h33);
      @(negedge clk);

      // R4: open-drain, no pull-up even on a rise
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'hFF);
      wr(2'd0, 8'h00);
      exp_drv("R4 od low", 8'hFF, 8'h00, 8'h00);
      @(negedge clk);
      wr(2'd0, 8'h3C);
      exp_drv("R4 od rise", 8'hC3, 8'h00, 8'h00);
      @(negedge clk);

      // R7: push-pull continuous
      wr(2'd1, 8'h00);
      repeat (3) @(negedge clk);
      exp_drv("R7 pp steady", 8'hC3, 8'h3C, 8'h00);
      @(negedge clk);

      // R8: two-edge synchronizer delay
      pad_in = 8'h96;
      push("R8 sync edge1 old", 3, 8'h00);
      @(negedge clk);
      push("R8 sync edge1", 3, 8'h00);
      @(negedge clk);
      push("R8 sync edge2", 3, 8'h96);
      @(negedge clk);

      // R9: pin read and ignored write to address 3
      rd("R9 pin read", 2'd3, 8'h96);
      wr(2'd3, 8'h11);
      rd("R9 data kept", 2'd0, 8'h3C);
      rd("R9 M0 kept", 2'd1, 8'h00);
      rd("R9 M1 kept", 2'd2, 8'hFF);
      exp_drv("R9 drives kept", 8'hC3, 8'h3C, 8'h00);
      @(negedge clk);
      @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule